// File: doc/BRIEF.md
# Serial Byte Transmitter with Frame Hold and Bit-Order Select

This block sends bytes out over a master-mode SPI link in mode 0. The host writes bytes into an eight-entry transmit queue. A serializer takes each byte from the queue and shifts it out on a data line. The serial clock is derived from the module clock through a programmable half-period divider. Each byte can be sent either most-significant bit first or reversed, so that the least-significant bit leaves first. The reversal is done in hardware as the byte is taken from the queue, so the host needs no lookup table.

Two framing modes are available. In the default mode every byte is its own frame: the select line rises for one half period between bytes. In hold mode the select line stays low, and the clock runs with no gap from one byte to the next as long as the queue has data. The next byte is taken from the queue on the final clock phase of the current byte. If the queue is empty when a held frame reaches a byte boundary, the frame closes and a sticky underrun flag is set. A write to a full queue is dropped and sets a sticky overflow flag. A level interrupt, gated by an enable, is raised while the queue holds half its depth or less, so the host can refill it in bursts.

Top module: `spi_tx_engine`

## Requirements
- R1: The queue holds up to 8 bytes and sends them strictly in the order they were written.
- R2: A write while the queue holds 8 bytes is discarded and sets `ovf_flag`. The flag stays set until a cycle with `flag_clr` high and no new overflow.
- R3: The serial clock is low whenever `cs_n` is high. Each low and high phase lasts `cfg_half` module-clock cycles, and a value of 0 acts as 1. `mosi` changes only while the serial clock is low, so the receiver samples it on the rising edge.
- R4: With `cfg_lsb_first`=0 bit 7 of each byte is sent first. With `cfg_lsb_first`=1 bit 0 is sent first.
- R5: With `cfg_hold`=1 and data in the queue, the next byte starts on the half period right after the last high phase, and `cs_n` stays low across the boundary.
- R6: With `cfg_hold`=0 each byte is framed alone: `cs_n` goes high for `cfg_half` cycles after the byte, then for one more cycle, before the next byte starts.
- R7: With `cfg_hold`=1 and an empty queue at the end of a byte, `cs_n` rises and `und_flag` is set. It is cleared only by `flag_clr`, and it is never set when `cfg_hold`=0.
- R8: `irq` equals `irq_en` AND (queue occupancy of 4 or fewer).
- R9: After reset `cs_n`=1, `sclk`=0, `mosi`=0, both flags are 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 8 | Byte to transmit |
| cfg_half | input | 8 | Serial clock half period in module clocks (0 acts as 1) |
| cfg_hold | input | 1 | Keep the frame open across bytes |
| cfg_lsb_first | input | 1 | Send bit 0 first |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clear the sticky flags |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Frame select, active low |
| irq | output | 1 | Queue-low interrupt level |
| ovf_flag | output | 1 | Sticky overflow flag |
| und_flag | output | 1 | Sticky hold-mode underrun flag |

## Verification
Overflow is the hardest case to reach, because the serializer drains the queue while it is being filled. To reach it, the stimulus sets a long half period and writes twelve bytes on consecutive cycles, which outruns the single pop the serializer makes in that window. Underrun needs a held frame whose queue runs dry at a byte boundary. The stimulus gets there by writing a short burst in hold mode and then stopping. A behavioural queue model follows every cycle, so each pop boundary and each gap is compared exactly.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } tx_state_e;

  function automatic logic [7:0] flip_byte(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

endpackage

// File: rtl/spi_tx_fifo.sv
module spi_tx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem_q[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= push_data;
  end
endmodule

// File: rtl/spi_tx_divider.sv
module spi_tx_divider #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          tick
);
  logic [HW-1:0] cnt_q, cnt_d, lim;

  assign lim  = (half == '0) ? HW'(1) : half;
  assign tick = run && (cnt_q >= lim - 1'b1);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_tx_serializer.sv
module spi_tx_serializer
  import spi_tx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         hold,
  input  logic         lsb_first,
  input  logic         q_empty,
  input  logic [W-1:0] q_head,
  output logic         q_pop,
  output logic         run,
  output logic         cs_n,
  output logic         sclk,
  output logic         mosi,
  output logic         underrun_evt
);
  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] LAST = BW'(W-1);

  tx_state_e     st_q, st_d;
  logic          ck_q, ck_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [W-1:0]  sh_q, sh_d, load;

  assign load = lsb_first ? flip_byte(q_head) : q_head;

  always_comb begin
    st_d         = st_q;
    ck_d         = ck_q;
    bit_d        = bit_q;
    sh_d         = sh_q;
    q_pop        = 1'b0;
    underrun_evt = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (!q_empty) begin
          q_pop = 1'b1;
          sh_d  = load;
          bit_d = '0;
          ck_d  = 1'b0;
          st_d  = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (!ck_q) begin
            ck_d = 1'b1;
          end else begin
            ck_d = 1'b0;
            if (bit_q == LAST) begin
              if (hold && !q_empty) begin
                q_pop = 1'b1;
                sh_d  = load;
                bit_d = '0;
              end else begin
                st_d         = ST_GAP;
                underrun_evt = hold;
              end
            end else begin
              sh_d  = {sh_q[W-2:0], 1'b0};
              bit_d = bit_q + 1'b1;
            end
          end
        end
      end
      ST_GAP: begin
        if (tick) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ck_q  <= 1'b0;
      bit_q <= '0;
      sh_q  <= '0;
    end else begin
      st_q  <= st_d;
      ck_q  <= ck_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end

  assign run  = (st_q != ST_IDLE);
  assign cs_n = (st_q != ST_SHIFT);
  assign sclk = ck_q;
  assign mosi = (st_q == ST_SHIFT) && sh_q[W-1];
endmodule

// File: rtl/spi_tx_engine.sv
module spi_tx_engine #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  parameter int HW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic [HW-1:0] cfg_half,
  input  logic          cfg_hold,
  input  logic          cfg_lsb_first,
  input  logic          irq_en,
  input  logic          flag_clr,
  output logic          sclk,
  output logic          mosi,
  output logic          cs_n,
  output logic          irq,
  output logic          ovf_flag,
  output logic          und_flag
);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  q_head;
  logic [CW-1:0] q_count;
  logic          q_full, q_empty, q_pop, run, tick, und_evt;
  logic          ovf_q, ovf_d, und_q, und_d;

  spi_tx_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_data),
    .pop(q_pop), .head(q_head), .count(q_count), .full(q_full), .empty(q_empty)
  );

  spi_tx_divider #(.HW(HW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .half(cfg_half), .tick(tick)
  );

  spi_tx_serializer #(.W(W)) u_ser (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hold(cfg_hold),
    .lsb_first(cfg_lsb_first), .q_empty(q_empty), .q_head(q_head),
    .q_pop(q_pop), .run(run), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .underrun_evt(und_evt)
  );

  always_comb begin
    ovf_d = (ovf_q && !flag_clr) || (wr_en && q_full);
    und_d = (und_q && !flag_clr) || und_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      und_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      und_q <= und_d;
    end
  end

  assign ovf_flag = ovf_q;
  assign und_flag = und_q;
  assign irq      = irq_en && (q_count <= CW'(DEPTH/2));
endmodule

// File: rtl/spi_tx_engine_chk.sv
module spi_tx_engine_chk #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  parameter int HW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [W-1:0]  wr_data,
  input logic [HW-1:0] cfg_half,
  input logic          cfg_hold,
  input logic          cfg_lsb_first,
  input logic          irq_en,
  input logic          flag_clr,
  input logic          sclk,
  input logic          mosi,
  input logic          cs_n,
  input logic          irq,
  input logic          ovf_flag,
  input logic          und_flag
);
  a_r3_clock_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  a_r3_data_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  a_r2_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  a_r7_underrun_closes_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(und_flag) |-> (cs_n && $past(cfg_hold)));

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind spi_tx_engine spi_tx_engine_chk #(.DEPTH(DEPTH), .W(W), .HW(HW)) u_chk (.*);

// File: tb/spi_tx_engine_test.sv
module spi_tx_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] cfg_half = 8'd2;
  logic       cfg_hold = 1'b0;
  logic       cfg_lsb_first = 1'b0;
  logic       irq_en = 1'b1;
  logic       flag_clr = 1'b0;
  logic       sclk, mosi, cs_n, irq, ovf_flag, und_flag;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  spi_tx_engine uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_half(cfg_half), .cfg_hold(cfg_hold), .cfg_lsb_first(cfg_lsb_first),
    .irq_en(irq_en), .flag_clr(flag_clr), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .irq(irq), .ovf_flag(ovf_flag), .und_flag(und_flag)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference: phase 0 idle, 1 sending, 2 gap
  logic [7:0] q[$];
  int   m_phase = 0;
  int   m_wait  = 0;
  int   m_hi    = 0;
  int   m_bitn  = 0;
  logic [7:0] m_cur = 8'h00;
  bit   m_ovf = 1'b0;
  bit   m_und = 1'b0;

  function automatic logic [7:0] order_byte(input logic [7:0] b, input bit lsbf);
    logic [7:0] o;
    o = b;
    if (lsbf) begin
      for (int k = 0; k < 8; k++) o[7-k] = b[k];
    end
    return o;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_phase = 0; m_wait = 0; m_hi = 0; m_bitn = 0; m_cur = 8'h00;
      m_ovf = 1'b0; m_und = 1'b0;
    end else begin
      int  h;
      bit  was_full;
      bit  set_und;
      h = (cfg_half == 0) ? 1 : int'(cfg_half);
      was_full = (q.size() == 8);
      set_und = 1'b0;
      if (m_phase == 0) begin
        m_wait = 0;
        if (q.size() > 0) begin
          m_cur = order_byte(q.pop_front(), cfg_lsb_first);
          m_bitn = 0; m_hi = 0; m_phase = 1;
        end
      end else begin
        if (m_wait >= h - 1) begin
          m_wait = 0;
          if (m_phase == 2) m_phase = 0;
          else if (m_hi == 0) m_hi = 1;
          else begin
            m_hi = 0;
            if (m_bitn == 7) begin
              if (cfg_hold && q.size() > 0) begin
                m_cur = order_byte(q.pop_front(), cfg_lsb_first);
                m_bitn = 0;
              end else begin
                m_phase = 2;
                set_und = cfg_hold;
              end
            end else begin
              m_cur = m_cur << 1;
              m_bitn++;
            end
          end
        end else m_wait++;
      end
      if (wr_en && !was_full) q.push_back(wr_data);
      m_ovf = (m_ovf && !flag_clr) || (wr_en && was_full);
      m_und = (m_und && !flag_clr) || set_und;
    end
  end

  task automatic cmp(input string tag, input string nm, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("R5/R6/R7", "cs_n", cs_n, m_phase != 1);
      cmp("R3", "sclk", sclk, m_phase == 1 && m_hi == 1);
      cmp("R1/R4", "mosi", mosi, m_phase == 1 && m_cur[7]);
      cmp("R8", "irq", irq, irq_en && q.size() <= 4);
      cmp("R2", "ovf_flag", ovf_flag, m_ovf);
      cmp("R7", "und_flag", und_flag, m_und);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 150000", cycles);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic put(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic settle();
    while (!(m_phase == 0 && q.size() == 0)) begin
      @(posedge clk); #1;
    end
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9: reset values seen at the ports
    cmp("R9", "cs_n", cs_n, 1'b1);
    cmp("R9", "sclk", sclk, 1'b0);
    cmp("R9", "mosi", mosi, 1'b0);
    cmp("R9", "ovf_flag", ovf_flag, 1'b0);
    cmp("R9", "und_flag", und_flag, 1'b0);
    cmp("R9", "irq", irq, 1'b1);
    @(posedge clk); #1;

    // R4 R6: single frames, MSB first
    cfg_half = 8'd2; cfg_hold = 1'b0; cfg_lsb_first = 1'b0;
    put(8'hA5); put(8'h3C);
    settle();

    // R5 R7: held frame, LSB first, runs dry
    cfg_half = 8'd3; cfg_hold = 1'b1; cfg_lsb_first = 1'b1;
    put(8'h81); put(8'h5A); put(8'hF0);
    settle();
    cmp("R7", "und_flag set", und_flag, 1'b1);
    flag_clr = 1'b1; @(posedge clk); #1 flag_clr = 1'b0;

    // R1 R2 R8: burst outruns the drain
    cfg_half = 8'd20; cfg_hold = 1'b1; cfg_lsb_first = 1'b0;
    for (int i = 0; i < 12; i++) put(8'(i * 17 + 3));
    cmp("R2", "ovf_flag set", ovf_flag, 1'b1);
    settle();
    flag_clr = 1'b1; @(posedge clk); #1 flag_clr = 1'b0;

    // R3 R8: zero half period, interrupt masked
    irq_en = 1'b0; cfg_half = 8'd0; cfg_hold = 1'b0;
    put(8'h6E); put(8'h01);
    settle();
    cmp("R7", "und_flag clear in unheld mode", und_flag, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule